// File: doc/BRIEF.md
# Compare-Match Timer

This block is a 10-bit up-counting timer for a microcontroller-style peripheral set. Software programs it through a small byte-wide write port. There is a control byte with run, pause, clock-select and period fields, a byte that holds the initial output level, and two bytes that hold the 10-bit compare A value. The counter value is always visible on an output port, and software cannot write it.

The counter advances once per count enable. The enable comes from one of five per-cycle internal tick inputs, or from a chosen edge of an external clock pin after a two-flop synchroniser. A coarse period compare wraps the counter back to zero. A fine compare against compare A pulses a flag and toggles the compare output pin.

Pause and off are different. Pausing freezes the count and then resumes it from the same value. Turning the timer off keeps the value until the next turn-on, and turning it on clears the count and reloads the output pin with its initial level.

Top module: `cmp_timer`

## Requirements
- R1: After reset the control byte, initial level and compare A are all zero, so the timer is off. The count is 0, the pin is 0 and both flags are 0.
- R2: The register map is: address 0 control (bit 7 pause, bits 6:4 clock select, bit 3 run, bits 2:0 period), address 1 initial level in bit 0, address 2 compare A bits 7:0, address 3 compare A bits 9:8 in data bits 1:0. While running and not paused, the count rises by exactly one per selected enable.
- R3: While the pause bit is 1, the count holds its value. After pause is cleared, counting continues from that held value.
- R4: A write that sets the run bit while it is 0 clears the count to 0 at that edge. Clearing the run bit leaves the count unchanged until the next turn-on.
- R5: At the turn-on edge, the compare pin takes the value of the initial-level bit.
- R6: Clock select codes 0 to 4 take tick_in bit [code] as the count enable, and the other tick bits are ignored. Code 5 never advances the count.
- R7: Code 6 counts rising edges and code 7 counts falling edges of ext_clk_pin. The pin goes through two synchronising flops, and each edge gives exactly one count.
- R8: With P equal to the period field, or 8 when the field is 0, a count taken at value P*128-1 wraps the counter to 0. In the cycle after that edge, match_p_o is 1 for one cycle.
- R9: When a count makes the counter equal compare A, match_a_o is 1 for exactly the one cycle after that edge. The compare pin inverts at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| tick_in | input | 5 | Per-cycle internal clock enables for select codes 0 to 4 |
| ext_clk_pin | input | 1 | External asynchronous count pin |
| count_o | output | 10 | Current counter value |
| match_a_o | output | 1 | Compare A match pulse |
| match_p_o | output | 1 | Period wrap pulse |
| cmp_pin_o | output | 1 | Compare output pin |

## Verification
The bench goes after the gap between pause and off. A design that cleared the count on pause would resume from 0, and one that kept the count at turn-on would resume from the old value. It sweeps every clock-select code while driving the tick bits that are not selected, so a wrong mux leg or a live reserved code shows up as extra counts. It steps the counter to the last value before each of the eight period wraps, so a design that mishandles period 0 as 8 or wraps one count late is caught. It checks the pin level at turn-on and at compare A values both below and above 255, which catches a pin that is not reloaded or a compare that ignores the high byte.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int CNT_W   = 10;
  localparam int PER_W   = 3;
  localparam int SEL_W   = 3;
  localparam int N_TICK  = 5;

  localparam logic [SEL_W-1:0] SEL_RESERVED = 3'd5;
  localparam logic [SEL_W-1:0] SEL_EXT_RISE = 3'd6;
  localparam logic [SEL_W-1:0] SEL_EXT_FALL = 3'd7;

  typedef struct packed {
    logic             pause;
    logic [SEL_W-1:0] sel;
    logic             run;
    logic [PER_W-1:0] period;
  } ctrl_t;

  // Last count value before the period wrap: P * 2^(cw-pw) - 1, field 0 meaning 2^pw.
  function automatic int unsigned period_top(input int unsigned p, input int unsigned pw,
                                             input int unsigned cw);
    int unsigned mult;
    mult = (p == 0) ? (1 << pw) : p;
    return mult * (1 << (cw - pw)) - 1;
  endfunction
endpackage

// File: rtl/cmp_timer_edge.sv
module cmp_timer_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/cmp_timer_clksel.sv
module cmp_timer_clksel
  import cmp_timer_pkg::*;
#(
  parameter int N_INT = N_TICK
) (
  input  logic [N_INT-1:0] tick_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_rise,
  input  logic             ext_fall,
  output logic             cnt_tick
);
  always_comb begin
    cnt_tick = 1'b0;
    if (sel == SEL_EXT_RISE)      cnt_tick = ext_rise;
    else if (sel == SEL_EXT_FALL) cnt_tick = ext_fall;
    else if (int'(sel) < N_INT)   cnt_tick = tick_in[sel];
  end
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
  import cmp_timer_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PER_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_set,
  input  logic          run_en,
  input  logic          cnt_tick,
  input  logic [PW-1:0] period,
  input  logic [CW-1:0] cmp_a,
  input  logic          init_lvl,
  output logic [CW-1:0] cnt,
  output logic          a_hit,
  output logic          p_hit,
  output logic          pin
);
  logic [CW-1:0] top_val, nxt;
  logic          step, wrap, a_eq;

  assign top_val = CW'(period_top(int'(period), PW, CW));
  assign step    = run_en & cnt_tick & ~on_set;
  assign wrap    = (cnt == top_val);
  assign nxt     = wrap ? '0 : cnt + 1'b1;
  assign a_eq    = (nxt == cmp_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      a_hit <= 1'b0;
      p_hit <= 1'b0;
      pin   <= 1'b0;
    end else begin
      a_hit <= step & a_eq;
      p_hit <= step & wrap;
      if (on_set) begin
        cnt <= '0;
        pin <= init_lvl;
      end else if (step) begin
        cnt <= nxt;
        if (a_eq) pin <= ~pin;
      end
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CW    = CNT_W,
  parameter int PW    = PER_W,
  parameter int NTICK = N_TICK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [NTICK-1:0] tick_in,
  input  logic             ext_clk_pin,
  output logic [CW-1:0]    count_o,
  output logic             match_a_o,
  output logic             match_p_o,
  output logic             cmp_pin_o
);
  localparam int HI_W = CW - 8;

  ctrl_t         ctrl_q;
  logic          init_q;
  logic [CW-1:0] cmpa_q;
  logic          on_set, run_en, cnt_tick, ext_rise, ext_fall;

  assign on_set = wr_en && (wr_addr == 2'd0) && wr_data[3] && !ctrl_q.run;
  assign run_en = ctrl_q.run && !ctrl_q.pause;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      init_q <= 1'b0;
      cmpa_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: ctrl_q <= ctrl_t'(wr_data);
        2'd1: init_q <= wr_data[0];
        2'd2: cmpa_q[7:0] <= wr_data;
        default: cmpa_q[CW-1:8] <= wr_data[HI_W-1:0];
      endcase
    end
  end

  cmp_timer_edge edge_i (
    .clk(clk), .rst_n(rst_n), .pin_async(ext_clk_pin), .rise(ext_rise), .fall(ext_fall)
  );

  cmp_timer_clksel #(.N_INT(NTICK)) sel_i (
    .tick_in(tick_in), .sel(ctrl_q.sel), .ext_rise(ext_rise), .ext_fall(ext_fall),
    .cnt_tick(cnt_tick)
  );

  cmp_timer_core #(.CW(CW), .PW(PW)) core_i (
    .clk(clk), .rst_n(rst_n), .on_set(on_set), .run_en(run_en), .cnt_tick(cnt_tick),
    .period(ctrl_q.period), .cmp_a(cmpa_q), .init_lvl(init_q),
    .cnt(count_o), .a_hit(match_a_o), .p_hit(match_p_o), .pin(cmp_pin_o)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          on_set,
  input logic          run_en,
  input logic          cnt_tick,
  input logic          init_q,
  input ctrl_t         ctrl_q,
  input logic [CW-1:0] count_o,
  input logic          match_a_o,
  input logic          match_p_o,
  input logic          cmp_pin_o
);
  // R2: a taken count moves the counter up by one or wraps it to zero
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cnt_tick && !on_set) |=> (count_o == $past(count_o) + 1'b1 || count_o == '0));

  // R3: a paused timer holds its count
  a_r3_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pause && !on_set) |=> $stable(count_o));

  // R4: turning the timer on clears the count
  a_r4_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    on_set |=> (count_o == '0));

  // R5: the pin takes the initial level at turn-on
  a_r5_pin_init: assert property (@(posedge clk) disable iff (!rst_n)
    on_set |=> (cmp_pin_o == $past(init_q)));

  // R6: the reserved select code never advances the count
  a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.sel == SEL_RESERVED && !on_set) |=> $stable(count_o));

  // R8: a period match leaves the counter at zero
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    match_p_o |-> (count_o == '0));

  // R9: a compare A match inverts the pin
  a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    match_a_o |-> (cmp_pin_o != $past(cmp_pin_o)));
endmodule

bind cmp_timer cmp_timer_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .on_set(on_set), .run_en(run_en), .cnt_tick(cnt_tick),
  .init_q(init_q), .ctrl_q(ctrl_q), .count_o(count_o), .match_a_o(match_a_o),
  .match_p_o(match_p_o), .cmp_pin_o(cmp_pin_o)
);

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] tick_in = '0;
  logic       ext_clk_pin = 1'b0;
  logic [9:0] count_o;
  logic       match_a_o, match_p_o, cmp_pin_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_in(tick_in), .ext_clk_pin(ext_clk_pin), .count_o(count_o),
    .match_a_o(match_a_o), .match_p_o(match_p_o), .cmp_pin_o(cmp_pin_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input logic [4:0] v, input int n);
    @(negedge clk);
    tick_in = v;
    repeat (n) @(negedge clk);
    tick_in = '0;
  endtask

  function automatic int top_of(input int p);
    return ((p == 0) ? 8 : p) * 128 - 1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 pin", int'(cmp_pin_o), 0);
    chk("R1 flags", int'({match_a_o, match_p_o}), 0);
    run(5'h1f, 8);
    chk("R1 off after reset", int'(count_o), 0);

    // cmpa far away so the pin is quiet
    wr(2'd3, 8'h03); wr(2'd2, 8'hff);

    // R4 on clears, R2 counting
    wr(2'd0, 8'h08);
    chk("R4 on clears", int'(count_o), 0);
    run(5'h01, 37);
    chk("R2 count by one", int'(count_o), 37);
    // R3 pause and resume
    wr(2'd0, 8'h88);
    run(5'h01, 20);
    chk("R3 pause holds", int'(count_o), 37);
    wr(2'd0, 8'h08);
    run(5'h01, 10);
    chk("R3 resume", int'(count_o), 47);
    // R4 off keeps residue
    wr(2'd0, 8'h00);
    run(5'h01, 20);
    chk("R4 off keeps", int'(count_o), 47);
    wr(2'd2, 8'h05);
    chk("R2 cmpa write leaves count", int'(count_o), 47);
    wr(2'd2, 8'hff);
    wr(2'd0, 8'h08);
    chk("R4 reon clears", int'(count_o), 0);

    // R6 select sweep
    for (int c = 0; c < 5; c++) begin
      wr(2'd0, 8'((c << 4) | 8));
      base = int'(count_o);
      run(~(5'd1 << c), 10);
      chk("R6 other ticks ignored", int'(count_o), base);
      run(5'd1 << c, 10);
      chk("R6 selected tick", int'(count_o), base + 10);
    end
    wr(2'd0, 8'h58);
    base = int'(count_o);
    run(5'h1f, 12);
    chk("R6 reserved code", int'(count_o), base);

    // R7 external edges
    for (int m = 0; m < 2; m++) begin
      wr(2'd0, (m == 0) ? 8'h68 : 8'h78);
      base = int'(count_o);
      for (int k = 0; k < 5; k++) begin
        @(negedge clk); ext_clk_pin = 1'b1;
        repeat (6) @(negedge clk);
        ext_clk_pin = 1'b0;
        repeat (6) @(negedge clk);
      end
      chk((m == 0) ? "R7 rising edges" : "R7 falling edges", int'(count_o), base + 5);
    end

    // R8 period sweep
    for (int p = 0; p < 8; p++) begin
      wr(2'd0, 8'h00);
      wr(2'd0, 8'(8 | p));
      run(5'h01, top_of(p));
      chk("R8 last value", int'(count_o), top_of(p));
      chk("R8 no early flag", int'(match_p_o), 0);
      run(5'h01, 1);
      chk("R8 wrap to zero", int'(count_o), 0);
      chk("R8 flag", int'(match_p_o), 1);
      run(5'h01, 1);
      chk("R8 flag one cycle", int'(match_p_o), 0);
    end

    // R5 and R9
    wr(2'd1, 8'h01); wr(2'd3, 8'h00); wr(2'd2, 8'd200);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h08);
    chk("R5 pin init high", int'(cmp_pin_o), 1);
    run(5'h01, 199);
    chk("R9 no early match", int'({match_a_o, cmp_pin_o}), 1);
    run(5'h01, 1);
    chk("R9 match count", int'(count_o), 200);
    chk("R9 flag", int'(match_a_o), 1);
    chk("R9 pin toggled", int'(cmp_pin_o), 0);
    run(5'h01, 1);
    chk("R9 flag one cycle", int'({match_a_o, cmp_pin_o}), 0);
    wr(2'd3, 8'h02); wr(2'd2, 8'hc5);
    run(5'h01, 508);
    chk("R9 high byte match", int'({match_a_o, cmp_pin_o}), 3);
    chk("R9 high count", int'(count_o), 709);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    chk("R5 off keeps pin", int'(cmp_pin_o), 1);
    wr(2'd0, 8'h08);
    chk("R5 pin init low", int'(cmp_pin_o), 0);
    chk("R4 on clears again", int'(count_o), 0);

    finish_run();
  end
endmodule